// File: doc/BRIEF.md
# Microcoded Datapath Sequencer

This block is the top-level controller of an arithmetic datapath. It fetches instruction words one at a time from an external program store through its program-counter output. It decodes each word and executes it on a register file that mixes narrow (16-bit) and wide (32-bit) registers. The datapath around the register file has a 32-bit add/subtract unit, a 32x16 signed multiplier, a register-to-register transfer and an internal table of constants.

A fixed walk of controller states sequences every instruction:
- an initial wait after reset;
- two fetch cycles;
- decode;
- execute.

Some instructions add states after execute. Conditional branches on the negative or zero flag pass through a branch state of their own. A handshake instruction parks the controller until a peripheral raises ready. An output instruction presents a register on a strobed data port.

Any arithmetic result that overflows, or that does not fit its destination register, freezes the sequencer in an error state. That state holds until reset.

Top module: `mcode_seq`

## Requirements
- R1: While rst_n is low, err and io_valid are 0 and prog_addr is 0. The first cycle after release is an initial wait state, and the first fetch then reads address 0.
- R2: An instruction word is 22 bits wide, laid out as follows:
  - opcode in [21:18], destination in [17:14], source A in [13:10], source B or constant index in [9:6], branch target in [5:0];
  - opcodes: 0 no-op, 1 add, 2 subtract, 3 multiply, 4 transfer, 5 load constant, 6 branch-if-negative, 7 branch-if-zero, 8 wait for ready, 9 output, 10 jump; any other value acts as a no-op.
- R3: Register addresses 0-7 are 16-bit registers, which read as sign-extended 32-bit values. Addresses 8-11 are 32-bit registers. Addresses 12-15 read as zero and ignore writes.
- R4: Add and subtract form the 32-bit signed A+B and A-B. Transfer copies A. The result goes to the destination register.
- R5: Multiply forms the signed product of the full 32-bit A and the low 16 bits of B, and writes it as a 32-bit value.
- R6: Load-constant writes entry k of the constant table, whose value is k*0x1111 truncated to 16 bits and read sign-extended, for k = 0..15.
- R7: An overflow triggers when an add, subtract or multiply result overflows signed 32 bits, or when any written value does not fit a 16-bit destination as a signed number. On overflow nothing is written, err rises, and err stays high with no further outputs until reset.
- R8: Negative and zero flags are taken from the last add, subtract, multiply, transfer or load result.
  - Branch-if-negative and branch-if-zero load the target when their flag is set, and otherwise fall through.
  - Jump always loads the target.
- R9: Output asserts io_valid for exactly one cycle, carrying register A on io_data. Wait-for-ready holds the sequencer until ready is high.
- R10: Two back-to-back output instructions produce io_valid pulses exactly 4 cycles apart, one each for fetch 0, fetch 1, decode and execute.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_addr | output | 6 | Program counter, address into the program store |
| prog_word | input | 22 | Instruction word read at prog_addr |
| ready | input | 1 | Peripheral ready for the wait instruction |
| io_valid | output | 1 | One-cycle strobe for io_data |
| io_data | output | 32 | Register value sent by the output instruction |
| err | output | 1 | Sticky overflow error |

## Verification
The ready handshake and instruction issue can overlap. The bench raises ready long after the sequencer has parked in its wait state. It judges the next output strobe by its cycle: the strobe must come after the ready edge and never before it.

Flag production and branch resolution fall in consecutive executes. A result and the branch that tests it are therefore placed back to back, in both the taken and the fall-through direction. Any skipped output that still shows up is a scoreboard mismatch.

Overflow and the output strobe are also contrasted. The output that follows a failing multiply must never appear.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_NOP  = 4'd0,
      OP_ADD  = 4'd1,
      OP_SUB  = 4'd2,
      OP_MUL  = 4'd3,
      OP_MOV  = 4'd4,
      OP_LDC  = 4'd5,
      OP_BRN  = 4'd6,
      OP_BRZ  = 4'd7,
      OP_WAIT = 4'd8,
      OP_OUT  = 4'd9,
      OP_JMP  = 4'd10
   } opcode_e;

   typedef enum logic [3:0] {
      S_WAIT_INIT,
      S_FETCH0,
      S_FETCH1,
      S_DECODE,
      S_EXEC,
      S_WAIT_RDY,
      S_BR_N,
      S_BR_Z,
      S_ERR_OVF
   } state_e;

endpackage

// File: rtl/mseq_regfile.sv
module mseq_regfile #(
   parameter int N16  = 8,
   parameter int N32  = 4,
   parameter int RA_W = 4,
   parameter int HW   = 16,
   parameter int DW   = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [RA_W-1:0] waddr,
   input  logic [DW-1:0]   wdata,
   input  logic [RA_W-1:0] raddr_a,
   input  logic [RA_W-1:0] raddr_b,
   output logic [DW-1:0]   rdata_a,
   output logic [DW-1:0]   rdata_b
);

   logic [N16-1:0][HW-1:0] narrow_q;
   logic [N32-1:0][DW-1:0] wide_q;

   for (genvar g = 0; g < N16; g++) begin : g_narrow
      logic [HW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              q <= '0;
         else if (we && waddr == RA_W'(g))        q <= wdata[HW-1:0];
      end
      assign narrow_q[g] = q;
   end

   for (genvar g = 0; g < N32; g++) begin : g_wide
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              q <= '0;
         else if (we && waddr == RA_W'(N16 + g))  q <= wdata;
      end
      assign wide_q[g] = q;
   end

   function automatic logic [DW-1:0] rd(input logic [RA_W-1:0] a,
                                        input logic [N16-1:0][HW-1:0] nq,
                                        input logic [N32-1:0][DW-1:0] wq);
      logic [DW-1:0] v;
      v = '0;
      for (int i = 0; i < N16; i++)
         if (a == RA_W'(i)) v = {{(DW-HW){nq[i][HW-1]}}, nq[i]};
      for (int j = 0; j < N32; j++)
         if (a == RA_W'(N16 + j)) v = wq[j];
      return v;
   endfunction

   always_comb begin
      rdata_a = rd(raddr_a, narrow_q, wide_q);
      rdata_b = rd(raddr_b, narrow_q, wide_q);
   end

endmodule

// File: rtl/mseq_const_rom.sv
module mseq_const_rom #(
   parameter int          CONST_N = 16,
   parameter int          IDX_W   = 4,
   parameter int          HW      = 16,
   parameter logic [15:0] STEP    = 16'h1111
) (
   input  logic [IDX_W-1:0] idx,
   output logic [HW-1:0]    value
);

   always_comb begin
      if (32'(idx) < CONST_N) value = HW'(32'(idx) * 32'(STEP));
      else                    value = '0;
   end

endmodule

// File: rtl/mseq_alu.sv
module mseq_alu
   import mseq_pkg::*;
#(
   parameter int DW = 32,
   parameter int HW = 16
) (
   input  opcode_e       op,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic          dst_narrow,
   output logic [DW-1:0] res,
   output logic          ovf
);

   localparam int PW = DW + HW;

   logic [DW:0]          sum_x;
   logic [PW-1:0]        prod;
   logic                 wide_ovf;
   logic                 narrow_bad;

   always_comb begin
      sum_x    = '0;
      prod     = '0;
      wide_ovf = 1'b0;
      res      = a;
      unique case (op)
         OP_ADD: begin
            sum_x    = {a[DW-1], a} + {b[DW-1], b};
            res      = sum_x[DW-1:0];
            wide_ovf = sum_x[DW] ^ sum_x[DW-1];
         end
         OP_SUB: begin
            sum_x    = {a[DW-1], a} - {b[DW-1], b};
            res      = sum_x[DW-1:0];
            wide_ovf = sum_x[DW] ^ sum_x[DW-1];
         end
         OP_MUL: begin
            prod     = PW'($signed(a) * $signed(b[HW-1:0]));
            res      = prod[DW-1:0];
            wide_ovf = !((&prod[PW-1:DW-1]) || !(|prod[PW-1:DW-1]));
         end
         OP_LDC:  res = b;
         default: res = a;
      endcase
      narrow_bad = dst_narrow && !((&res[DW-1:HW-1]) || !(|res[DW-1:HW-1]));
      ovf        = wide_ovf || narrow_bad;
   end

endmodule

// File: rtl/mcode_seq.sv
module mcode_seq
   import mseq_pkg::*;
#(
   parameter int          PC_W    = 6,
   parameter int          RA_W    = 4,
   parameter int          N16     = 8,
   parameter int          N32     = 4,
   parameter int          HW      = 16,
   parameter int          DW      = 32,
   parameter int          CONST_N = 16,
   parameter logic [15:0] CSTEP   = 16'h1111,
   localparam int         IW      = OP_W + 3*RA_W + PC_W
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [PC_W-1:0] prog_addr,
   input  logic [IW-1:0]   prog_word,
   input  logic            ready,
   output logic            io_valid,
   output logic [DW-1:0]   io_data,
   output logic            err
);

   if (N16 + N32 > 2**RA_W) begin : g_bad_regs
      $error("register file does not fit the address field");
   end
   if (CONST_N > 2**RA_W) begin : g_bad_const
      $error("constant table larger than its index field");
   end
   if (HW >= DW) begin : g_bad_width
      $error("narrow width must be below the wide width");
   end

   state_e          state;
   logic [PC_W-1:0] pc;
   logic [IW-1:0]   ir;
   logic [DW-1:0]   opa, opb;
   logic            flag_n, flag_z;

   opcode_e         op;
   logic [RA_W-1:0] f_dst, f_srca, f_srcb;
   logic [PC_W-1:0] f_tgt;

   assign op     = opcode_e'(ir[IW-1 -: OP_W]);
   assign f_dst  = ir[PC_W + 3*RA_W - 1 -: RA_W];
   assign f_srca = ir[PC_W + 2*RA_W - 1 -: RA_W];
   assign f_srcb = ir[PC_W + RA_W - 1 -: RA_W];
   assign f_tgt  = ir[PC_W-1:0];

   logic [DW-1:0] rd_a, rd_b, alu_res;
   logic [HW-1:0] cval;
   logic          alu_ovf, is_write, rf_we;

   assign is_write = (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL) ||
                     (op == OP_MOV) || (op == OP_LDC);
   assign rf_we    = (state == S_EXEC) && is_write && !alu_ovf;

   mseq_regfile #(.N16(N16), .N32(N32), .RA_W(RA_W), .HW(HW), .DW(DW)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (rf_we),
      .waddr   (f_dst),
      .wdata   (alu_res),
      .raddr_a (f_srca),
      .raddr_b (f_srcb),
      .rdata_a (rd_a),
      .rdata_b (rd_b)
   );

   mseq_const_rom #(.CONST_N(CONST_N), .IDX_W(RA_W), .HW(HW), .STEP(CSTEP)) u_crom (
      .idx   (f_srcb),
      .value (cval)
   );

   mseq_alu #(.DW(DW), .HW(HW)) u_alu (
      .op         (op),
      .a          (opa),
      .b          (opb),
      .dst_narrow (f_dst < RA_W'(N16)),
      .res        (alu_res),
      .ovf        (alu_ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_WAIT_INIT;
         pc       <= '0;
         ir       <= '0;
         opa      <= '0;
         opb      <= '0;
         flag_n   <= 1'b0;
         flag_z   <= 1'b0;
         io_valid <= 1'b0;
         io_data  <= '0;
      end else begin
         io_valid <= 1'b0;
         unique case (state)
            S_WAIT_INIT: state <= S_FETCH0;
            S_FETCH0:    state <= S_FETCH1;
            S_FETCH1: begin
               ir    <= prog_word;
               pc    <= pc + 1'b1;
               state <= S_DECODE;
            end
            S_DECODE: begin
               opa   <= rd_a;
               opb   <= (op == OP_LDC) ? {{(DW-HW){cval[HW-1]}}, cval} : rd_b;
               state <= S_EXEC;
            end
            S_EXEC: begin
               state <= S_FETCH0;
               if (is_write) begin
                  if (alu_ovf) state <= S_ERR_OVF;
                  else begin
                     flag_n <= alu_res[DW-1];
                     flag_z <= (alu_res == '0);
                  end
               end else begin
                  unique case (op)
                     OP_BRN:  state <= S_BR_N;
                     OP_BRZ:  state <= S_BR_Z;
                     OP_WAIT: state <= S_WAIT_RDY;
                     OP_OUT: begin
                        io_valid <= 1'b1;
                        io_data  <= opa;
                     end
                     OP_JMP:  pc <= f_tgt;
                     default: ;
                  endcase
               end
            end
            S_BR_N: begin
               if (flag_n) pc <= f_tgt;
               state <= S_FETCH0;
            end
            S_BR_Z: begin
               if (flag_z) pc <= f_tgt;
               state <= S_FETCH0;
            end
            S_WAIT_RDY: if (ready) state <= S_FETCH0;
            S_ERR_OVF:  state <= S_ERR_OVF;
            default:    state <= S_ERR_OVF;
         endcase
      end
   end

   assign prog_addr = pc;
   assign err       = (state == S_ERR_OVF);

endmodule

// File: rtl/mcode_seq_chk.sv
module mcode_seq_chk
   import mseq_pkg::*;
#(
   parameter int PC_W = 6
) (
   input logic            clk,
   input logic            rst_n,
   input state_e          state,
   input logic            err,
   input logic            io_valid,
   input logic            ready,
   input logic [PC_W-1:0] prog_addr
);

   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   // R7
   err_from_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> $past(state) == S_EXEC);

   // R9
   one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_valid |=> !io_valid);

   // R9
   hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_WAIT_RDY && !ready) |=> state == S_WAIT_RDY);

   // R10
   decode_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state == S_DECODE |=> $stable(prog_addr));

   // R1
   init_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state == S_WAIT_INIT |=> state == S_FETCH0);

   // R7
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !io_valid);

endmodule

bind mcode_seq mcode_seq_chk #(.PC_W(PC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .state     (state),
   .err       (err),
   .io_valid  (io_valid),
   .ready     (ready),
   .prog_addr (prog_addr)
);

// File: tb/sim_mcode_seq.sv
`timescale 1ns/1ps
module sim_mcode_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  prog_addr;
   logic [21:0] prog_word;
   logic        ready = 1'b0;
   logic        io_valid;
   logic [31:0] io_data;
   logic        err;

   logic [21:0] prog [64];
   assign prog_word = prog[prog_addr];

   always #2 clk = ~clk;

   mcode_seq u0 (
      .clk(clk), .rst_n(rst_n), .prog_addr(prog_addr), .prog_word(prog_word),
      .ready(ready), .io_valid(io_valid), .io_data(io_data), .err(err)
   );

   typedef struct {
      logic [31:0] data;
      string       req;
      int          after;
   } exp_t;

   exp_t sb[$];
   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int last_pulse = -100;

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // R2 field layout: op[21:18] dst[17:14] srcA[13:10] srcB[9:6] tgt[5:0]
   function automatic logic [21:0] ins(input int op, input int d, input int a,
                                       input int b, input int t);
      return {4'(op), 4'(d), 4'(a), 4'(b), 6'(t)};
   endfunction

   task automatic push(input logic [31:0] d, input string req, input int after);
      exp_t e;
      e.data = d; e.req = req; e.after = after;
      sb.push_back(e);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 20000) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   // monitor
   always @(negedge clk) begin
      if (rst_n && io_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R7 unexpected output", io_data, 32'h0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(io_data == e.data, e.req, io_data, e.data);
            if (e.after > 0)
               check(cyc > e.after, "R9 output before ready", cyc, e.after);
            if (e.req == "R10")
               check(cyc - last_pulse == 4, "R10 pulse spacing", cyc - last_pulse, 4);
         end
         last_pulse = cyc;
      end
   end

   initial begin
      int tmp;
      logic signed [31:0] m1, m2;
      m1 = -13108 * 13107;
      m2 = 30583 * 30583;
      for (int i = 0; i < 64; i++) prog[i] = ins(0, 0, 0, 0, 0);
      // phase 1 program
      prog[0]  = ins(5, 0, 0, 3, 0);     // r0 = 0x3333
      prog[1]  = ins(5, 1, 0, 15, 0);    // r1 = 0xFFFF
      prog[2]  = ins(1, 8, 0, 1, 0);     // r8 = r0 + r1
      prog[3]  = ins(9, 0, 8, 0, 0);
      prog[4]  = ins(9, 0, 1, 0, 0);
      prog[5]  = ins(2, 2, 1, 0, 0);     // r2 = r1 - r0
      prog[6]  = ins(9, 0, 2, 0, 0);
      prog[7]  = ins(6, 0, 0, 0, 9);     // taken
      prog[8]  = ins(9, 0, 0, 0, 0);     // skipped
      prog[9]  = ins(4, 12, 0, 0, 0);    // write to unmapped
      prog[10] = ins(9, 0, 12, 0, 0);
      prog[11] = ins(5, 3, 0, 0, 0);     // zero
      prog[12] = ins(7, 0, 0, 0, 14);    // taken
      prog[13] = ins(9, 0, 0, 0, 0);     // skipped
      prog[14] = ins(3, 9, 2, 0, 0);     // r9 = r2 * r0
      prog[15] = ins(9, 0, 9, 0, 0);
      prog[16] = ins(7, 0, 0, 0, 18);    // not taken
      prog[17] = ins(9, 0, 0, 0, 0);
      prog[18] = ins(8, 0, 0, 0, 0);     // wait ready
      prog[19] = ins(9, 0, 8, 0, 0);
      prog[20] = ins(9, 0, 8, 0, 0);
      prog[21] = ins(5, 4, 0, 7, 0);     // r4 = 0x7777
      prog[22] = ins(3, 10, 4, 4, 0);
      prog[23] = ins(9, 0, 10, 0, 0);
      prog[24] = ins(3, 11, 10, 4, 0);   // overflows 32 bits
      prog[25] = ins(9, 0, 10, 0, 0);    // must not appear

      push(32'h0000_3332, "R2", 0);
      push(32'hFFFF_FFFF, "R6", 0);
      push(32'hFFFF_CCCC, "R4", 0);
      push(32'h0, "R3", 0);
      push(m1, "R5", 0);
      push(32'h0000_3333, "R8", 0);
      push(32'h0000_3332, "R9", 400);
      push(32'h0000_3332, "R10", 0);
      push(m2, "R5", 0);

      repeat (3) @(negedge clk);
      check(err == 1'b0, "R1 err in reset", err, 0);
      check(io_valid == 1'b0, "R1 io_valid in reset", io_valid, 0);
      check(prog_addr == 6'd0, "R1 pc in reset", prog_addr, 0);
      rst_n = 1'b1;

      wait (cyc >= 400);
      @(negedge clk);
      ready = 1'b1;

      wait (err == 1'b1);
      tmp = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (err !== 1'b1) tmp++;
      end
      check(tmp == 0, "R7 err sticky", tmp, 0);
      check(sb.size() == 0, "R9 all outputs seen", sb.size(), 0);

      // phase 2
      rst_n = 1'b0;
      ready = 1'b0;
      repeat (3) @(negedge clk);
      check(err == 1'b0, "R7 err cleared by reset", err, 0);
      check(prog_addr == 6'd0, "R1 pc after reset", prog_addr, 0);
      for (int i = 0; i < 64; i++) prog[i] = ins(0, 0, 0, 0, 0);
      prog[0] = ins(5, 0, 0, 7, 0);      // r0 = 0x7777
      prog[1] = ins(10, 0, 0, 0, 3);     // jump
      prog[2] = ins(9, 0, 0, 0, 0);      // skipped
      prog[3] = ins(9, 0, 0, 0, 0);
      prog[4] = ins(1, 1, 0, 0, 0);      // 0xEEEE does not fit r1
      prog[5] = ins(9, 0, 1, 0, 0);      // must not appear
      push(32'h0000_7777, "R8", 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(prog_addr == 6'd0, "R1 first fetch address", prog_addr, 0);
      wait (err == 1'b1);
      repeat (20) @(negedge clk);
      check(err == 1'b1, "R7 narrow fit overflow", err, 1);
      check(sb.size() == 0, "R8 jump output seen", sb.size(), 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule